// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides a double-width unsigned dividend by a single-width unsigned divisor. It uses the restoring long-division method and produces one quotient bit per clock. After a start request it loads three registers. The working remainder takes the whole dividend. The shifting divisor register holds the divisor in its upper half. The quotient register is cleared. The block then runs one pass more than the divisor has bits.

Each pass subtracts the shifting divisor from the working remainder. If the difference does not go below zero, the difference is kept and a 1 enters the quotient. Otherwise the old remainder is kept and a 0 enters the quotient. The divisor register then moves right one place. A one-cycle completion pulse marks the end of the run. The results stay on the outputs until the next accepted start.

Two flags are captured when the operands are loaded. One reports a zero divisor. The other reports a dividend whose upper half is not below the divisor, so that the true quotient cannot fit in the quotient width. Neither case is corrected: the outputs are whatever the passes produce.

Top module: `udiv_restoring`

## Requirements
- R1: While reset is asserted, and after it is released, busy_o, done_o, div_zero_o, ovf_o, quotient_o and remainder_o are all zero.
- R2: A start accepted while idle makes busy_o high from the next cycle for exactly DVSR_W+1 cycles (33 by default).
- R3: done_o is high for exactly one cycle, the first cycle after busy_o falls, and busy_o is low in that cycle.
- R4: When the divisor is non-zero and the upper half of the dividend is below it, quotient_o equals floor(dividend/divisor) and remainder_o equals dividend mod divisor when done_o is high, and both flags are low.
- R5: Operands with the most significant bits set, such as a divisor of all ones or a quotient of all ones, give the exact result of R4. The negative test of a pass must not misread a large remainder as negative.
- R6: A start request while busy_o is high is ignored. The running division keeps its operands and its length.
- R7: A zero divisor sets div_zero_o with done_o and clears ovf_o. quotient_o is then all ones and remainder_o equals the lower half of the dividend.
- R8: A non-zero divisor not greater than the upper half of the dividend sets ovf_o with done_o, including the case where that half equals the divisor.
- R9: While idle with no start, quotient_o, remainder_o and both flags hold their values, even when the operand inputs change.
- R10: A start in the cycle where done_o is high is accepted. busy_o is high in the next cycle and done_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a division, taken only while idle |
| dividend_i | input | 2*DVSR_W | Unsigned dividend, sampled on an accepted start |
| divisor_i | input | DVSR_W | Unsigned divisor, sampled on an accepted start |
| quotient_o | output | DVSR_W | Quotient register |
| remainder_o | output | DVSR_W | Lower half of the working remainder |
| busy_o | output | 1 | High while passes are running |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divisor was zero |
| ovf_o | output | 1 | Quotient does not fit in DVSR_W bits |

## Verification
The bench drives operands whose top bits are set, for example an all-ones divisor and a dividend one step below the overflow limit. A design that took the top bit of a plain same-width difference as the sign would drop quotient bits and return a wrong remainder. It counts the busy cycles of every run, so a loop that is one pass short or one pass long is caught. A short loop also leaves the result shifted by one place. It sends a start in the middle of a run and another in the completion cycle. A design that restarted on the first, or missed the second, would return the wrong operands' result or hang. It also tests the zero-divisor case and the case where the dividend's upper half equals the divisor. A comparator that used > instead of >= would miss the overflow flag there.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rdiv_state_e;

endpackage

// File: rtl/rdiv_step.sv
// One restoring pass: trial subtract with a one-bit extension and restore by mux.
module rdiv_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dvr_i,
  output logic [W-1:0] rem_o,
  output logic         qbit_o
);

  logic [W:0] diff;
  logic       borrow;

  always_comb begin
    diff   = {1'b0, rem_i} - {1'b0, dvr_i};
    borrow = diff[W];
    qbit_o = ~borrow;
    rem_o  = borrow ? rem_i : diff[W-1:0];
  end

endmodule

// File: rtl/rdiv_ctrl.sv
// Pass counter and run/idle sequencing.
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int ITER = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(ITER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  rdiv_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             accept, last_pass;

  always_comb begin
    accept    = start_i && (st_q == ST_IDLE);
    last_pass = (st_q == ST_RUN) && (cnt_q == LAST);
    st_d      = st_q;
    cnt_d     = cnt_q;
    done_d    = last_pass;
    if (accept) begin
      st_d  = ST_RUN;
      cnt_d = '0;
    end else if (st_q == ST_RUN) begin
      cnt_d = cnt_q + 1'b1;
      if (last_pass) st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign load_o = accept;
  assign step_o = (st_q == ST_RUN);
  assign busy_o = (st_q == ST_RUN);
  assign done_o = done_q;

endmodule

// File: rtl/rdiv_datapath.sv
// Remainder, shifting divisor and quotient registers plus operand flags.
module rdiv_datapath #(
  parameter int DVSR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  step_i,
  input  logic [2*DVSR_W-1:0]   dividend_i,
  input  logic [DVSR_W-1:0]     divisor_i,
  output logic [DVSR_W-1:0]     quo_o,
  output logic [DVSR_W-1:0]     rem_o,
  output logic                  dz_o,
  output logic                  ovf_o
);

  localparam int DVND_W = 2 * DVSR_W;

  logic [DVND_W-1:0] rem_q, rem_d, rem_step;
  logic [DVND_W-1:0] dvr_q, dvr_d;
  logic [DVSR_W-1:0] quo_q, quo_d;
  logic              dz_q, dz_d, ovf_q, ovf_d;
  logic              qbit;
  logic              rem_en, dvr_en, quo_en, flag_en;

  rdiv_step #(.W(DVND_W)) u_step (
    .rem_i  (rem_q),
    .dvr_i  (dvr_q),
    .rem_o  (rem_step),
    .qbit_o (qbit)
  );

  always_comb begin
    rem_en  = load_i || step_i;
    dvr_en  = load_i || step_i;
    quo_en  = load_i || step_i;
    flag_en = load_i;
    if (load_i) begin
      rem_d = dividend_i;
      dvr_d = {divisor_i, {DVSR_W{1'b0}}};
      quo_d = '0;
    end else begin
      rem_d = rem_step;
      dvr_d = dvr_q >> 1;
      quo_d = {quo_q[DVSR_W-2:0], qbit};
    end
    dz_d  = (divisor_i == '0);
    ovf_d = (divisor_i != '0) && (dividend_i[DVND_W-1:DVSR_W] >= divisor_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvr_q <= '0;
      quo_q <= '0;
      dz_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (rem_en)  rem_q <= rem_d;
      if (dvr_en)  dvr_q <= dvr_d;
      if (quo_en)  quo_q <= quo_d;
      if (flag_en) begin
        dz_q  <= dz_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q[DVSR_W-1:0];
  assign dz_o  = dz_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/udiv_restoring.sv
module udiv_restoring #(
  parameter int DVSR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [2*DVSR_W-1:0]   dividend_i,
  input  logic [DVSR_W-1:0]     divisor_i,
  output logic [DVSR_W-1:0]     quotient_o,
  output logic [DVSR_W-1:0]     remainder_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  div_zero_o,
  output logic                  ovf_o
);

  localparam int ITER = DVSR_W + 1;

  logic rst_meta_n, rst_sync_n;
  logic load, step;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rdiv_ctrl #(.ITER(ITER)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  rdiv_datapath #(.DVSR_W(DVSR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load),
    .step_i     (step),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quo_o      (quotient_o),
    .rem_o      (remainder_o),
    .dz_o       (div_zero_o),
    .ovf_o      (ovf_o)
  );

endmodule

// File: rtl/udiv_restoring_chk.sv
module udiv_restoring_chk #(
  parameter int DVSR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DVSR_W-1:0] quotient_o,
  input logic [DVSR_W-1:0] remainder_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              div_zero_o,
  input logic              ovf_o
);

  localparam int ITER  = DVSR_W + 1;
  localparam int CW    = $clog2(ITER + 1) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  // R2: a start taken while idle raises busy next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R2: the run lasts exactly ITER cycles
  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == CW'(ITER)));

  // R3: done is a single-cycle pulse with busy low
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_fall_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R6: start during a run (not its last cycle) does not end or restart it
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && (run_cnt != CW'(ITER - 1))) |=> (busy_o && !done_o));

  // R7: zero divisor gives an all-ones quotient and no overflow flag
  assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div_zero_o) |-> ((&quotient_o) && !ovf_o));

  // R9: idle without start keeps the results
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)
                               && $stable(div_zero_o) && $stable(ovf_o)));

endmodule

bind udiv_restoring udiv_restoring_chk #(.DVSR_W(DVSR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_i     (start_i),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .div_zero_o  (div_zero_o),
  .ovf_o       (ovf_o)
);

// File: tb/sim_udiv_restoring.sv
`timescale 1ns/1ps
module sim_udiv_restoring;

  localparam int W    = 32;
  localparam int ITER = W + 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [2*W-1:0]  dividend_i;
  logic [W-1:0]    divisor_i;
  logic [W-1:0]    quotient_o, remainder_o;
  logic            busy_o, done_o, div_zero_o, ovf_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  udiv_restoring #(.DVSR_W(W)) u0 (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .dividend_i (dividend_i), .divisor_i (divisor_i),
    .quotient_o (quotient_o), .remainder_o (remainder_o),
    .busy_o (busy_o), .done_o (done_o),
    .div_zero_o (div_zero_o), .ovf_o (ovf_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive start for one cycle; returns at the falling edge after the load edge.
  task automatic issue(input logic [63:0] a, input logic [31:0] b);
    @(negedge clk);
    start_i = 1'b1; dividend_i = a; divisor_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(inout int n);
    while (busy_o && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input logic [63:0] a, input logic [31:0] b, input string req);
    logic [63:0] eq, er;
    eq = a / {32'd0, b};
    er = a % {32'd0, b};
    chk(quotient_o == eq[31:0], {req, " quotient"}, quotient_o, eq);
    chk(remainder_o == er[31:0], {req, " remainder"}, remainder_o, er);
    chk(!div_zero_o && !ovf_o, {req, " flags"}, {div_zero_o, ovf_o}, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, div_zero_o, ovf_o} == 0, "R1 flags in reset", {busy_o, done_o, div_zero_o, ovf_o}, 0);
    chk(quotient_o == 0 && remainder_o == 0, "R1 results in reset", {quotient_o, remainder_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o} == 0 && quotient_o == 0, "R1 after release", {busy_o, done_o, quotient_o}, 0);
  endtask

  task automatic t_divide(input logic [63:0] a, input logic [31:0] b, input string req);
    int n = 0;
    issue(a, b);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    wait_done(n);
    chk(n == ITER, "R2 busy length", n, ITER);
    chk(done_o == 1'b1, "R3 done after busy", done_o, 1);
    check_result(a, b, req);
    @(negedge clk);
    chk(done_o == 1'b0, "R3 done single cycle", done_o, 0);
  endtask

  task automatic t_zero();
    int n = 0;
    logic [63:0] a = 64'h0123_4567_89AB_CDEF;
    issue(a, 32'd0);
    wait_done(n);
    chk(n == ITER, "R7 busy length", n, ITER);
    chk(done_o && div_zero_o && !ovf_o, "R7 flags", {done_o, div_zero_o, ovf_o}, 3'b110);
    chk(quotient_o == 32'hFFFF_FFFF, "R7 quotient", quotient_o, 32'hFFFF_FFFF);
    chk(remainder_o == a[31:0], "R7 remainder", remainder_o, a[31:0]);
  endtask

  task automatic t_ovf(input logic [63:0] a, input logic [31:0] b);
    int n = 0;
    issue(a, b);
    wait_done(n);
    chk(done_o && ovf_o && !div_zero_o, "R8 overflow flag", {done_o, ovf_o, div_zero_o}, 3'b110);
  endtask

  task automatic t_busy_start();
    int n = 0;
    logic [63:0] a = 64'h0000_0003_DEAD_BEEF;
    logic [31:0] b = 32'h0000_1234;
    issue(a, b);
    for (int i = 0; i < 5; i++) begin n++; @(negedge clk); end
    start_i = 1'b1; dividend_i = 64'd100; divisor_i = 32'd7;
    n++; @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R6 still busy", busy_o, 1);
    wait_done(n);
    chk(n == ITER, "R6 length unchanged", n, ITER);
    check_result(a, b, "R6");
  endtask

  task automatic t_hold();
    logic [31:0] q, r;
    t_divide(64'd1_000_003, 32'd97, "R4");
    q = quotient_o; r = remainder_o;
    dividend_i = 64'hFFFF_0000_FFFF_0000; divisor_i = 32'd0;
    repeat (4) @(negedge clk);
    chk(quotient_o == q && remainder_o == r, "R9 results held", {quotient_o, remainder_o}, {q, r});
    chk(!div_zero_o && !ovf_o && !busy_o, "R9 flags held", {div_zero_o, ovf_o, busy_o}, 0);
  endtask

  task automatic t_back2back();
    int n = 0;
    logic [63:0] a1 = 64'd55, a2 = 64'h0000_0000_FFFF_FFFF;
    logic [31:0] b1 = 32'd8,  b2 = 32'd16;
    issue(a1, b1);
    wait_done(n);
    chk(done_o == 1'b1, "R10 first done", done_o, 1);
    check_result(a1, b1, "R10 first");
    start_i = 1'b1; dividend_i = a2; divisor_i = b2;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R10 restart accepted", {busy_o, done_o}, 2'b10);
    n = 0;
    wait_done(n);
    chk(n == ITER, "R10 second length", n, ITER);
    check_result(a2, b2, "R10 second");
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_divide(64'd100, 32'd7, "R4 small");
    t_divide(64'd0, 32'd5, "R4 zero dividend");
    t_divide(64'd41, 32'd41, "R4 equal");
    t_divide(64'd3, 32'd9, "R4 dividend below divisor");
    t_divide(64'hFFFF_FFFE_FFFF_FFFF, 32'hFFFF_FFFF, "R5 all-ones divisor");
    t_divide(64'h8000_0000_0000_0000, 32'h8000_0001, "R5 top bits");
    t_divide(64'h0000_0004_FFFF_FFFF, 32'd5, "R5 max quotient");
    t_zero();
    t_ovf(64'h0000_0005_0000_0000, 32'd3);
    t_ovf(64'h0000_0007_0000_0000, 32'd7);
    t_busy_start();
    t_hold();
    t_back2back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule